// File: doc/BRIEF.md
# Microprogram Alteration Unit

This block is the decision and control-flag unit of a small microprogrammed computer. At its centre is a five-bit microsubroutine loop counter. The microprogram can load it with a constant carried in the microinstruction or with the low bits of the arithmetic data bus. It can also step it down by one. Completion of a loop is signalled when the counter underflows from all zeros to all ones, not when it reaches zero. That event appears as a registered one-cycle pulse.

Next to the counter sit four single-bit flip-flops, each with its own set and clear command. They hold the carry fed into the adder, the end carry shifted in during shift operations, the memory direction (read or write), and a decision flag. The decision flag drives a branch-select output, which the sequencer uses to choose between two next microinstructions. Decoding of the microinstruction and the control store are outside this block.

Top module: `alt_unit`

## Requirements
- R1: When `cntLoadImm` is high, the counter takes `immVal` at the next clock edge. This happens regardless of `cntLoadBus` and `cntDec`.
- R2: When `cntLoadBus` is high and `cntLoadImm` is low, the counter takes bits [4:0] of `busVal` and ignores the higher bus bits. When both load commands are high, the immediate value wins.
- R3: When `cntDec` is high and neither load command is high, the counter decreases by one, modulo 32. When a load command is high in the same cycle, the load wins and no decrement occurs.
- R4: `wrapPulse` is high for exactly the one cycle that follows an edge on which a decrement took the counter from 5'b00000 to 5'b11111. A load of 5'b11111, or any other decrement, leaves it low.
- R5: Flag bit 0 (`flagSet[0]`/`flagClr[0]`) drives `carryIn`. A lone set command makes it 1 at the next edge, and a lone clear command makes it 0.
- R6: Flag bit 1 drives `endCarry` and follows the same set/clear rule.
- R7: Flag bit 2 drives `memWrite` (1 = write, 0 = read) and follows the same set/clear rule.
- R8: Flag bit 3 holds the decision flag and follows the same set/clear rule. `branchSel` is 1 (take the alternate sequence) exactly when that flag is 1.
- R9: Asserting the set and clear commands of a flag together leaves that flag unchanged.
- R10: A synchronous `rst` clears the counter, all four flags, `branchSel` and `wrapPulse` at the next edge. Reset overrides every other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cntLoadImm | input | 1 | Load counter from immediate |
| cntLoadBus | input | 1 | Load counter from data bus low bits |
| cntDec | input | 1 | Decrement counter |
| immVal | input | CNT_W (5) | Immediate counter value |
| busVal | input | BUS_W (16) | Arithmetic data bus |
| flagSet | input | 4 | Per-flag set commands (bit 0 carry-in, 1 end carry, 2 memory write, 3 decision) |
| flagClr | input | 4 | Per-flag clear commands, same bit order |
| cntValue | output | CNT_W (5) | Current counter value |
| wrapPulse | output | 1 | One-cycle underflow-wrap pulse |
| carryIn | output | 1 | Adder initial carry |
| endCarry | output | 1 | Shift end carry |
| memWrite | output | 1 | Memory direction, 1 = write |
| branchSel | output | 1 | Branch choice from the decision flag |

## Verification
The bench builds the block with the counter at its five-bit default and with the bus narrowed to 12 bits. This keeps bits above the counter width on the bus, so the test can show that only the low five bits are loaded. Five bits bring the underflow from 0 to 31 within a few decrements. With the same width, the bench can also load 31 directly and show that this raises no pulse. Priority collisions are covered: both loads together, a load with a decrement, and set with clear on each flag.

// File: rtl/alt_pkg.sv
package alt_pkg;
  localparam int FLAG_N     = 4;
  localparam int FLAG_CIN   = 0;
  localparam int FLAG_ECY   = 1;
  localparam int FLAG_MEMWR = 2;
  localparam int FLAG_DEC   = 3;

  typedef struct packed {
    logic              ldImm;
    logic              ldBus;
    logic              dec;
    logic [FLAG_N-1:0] set;
    logic [FLAG_N-1:0] clr;
  } altStrobes_t;
endpackage

// File: rtl/alt_ctrl.sv
module alt_ctrl
  import alt_pkg::*;
(
  input  logic              cntLoadImm,
  input  logic              cntLoadBus,
  input  logic              cntDec,
  input  logic [FLAG_N-1:0] flagSet,
  input  logic [FLAG_N-1:0] flagClr,
  output altStrobes_t       strobes
);
  // Priority: immediate load, then bus load, then decrement.
  always_comb begin
    strobes.ldImm = cntLoadImm;
    strobes.ldBus = cntLoadBus & ~cntLoadImm;
    strobes.dec   = cntDec & ~cntLoadImm & ~cntLoadBus;
  end

  // A set and a clear on the same flag cancel out.
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flagCmd
    assign strobes.set[i] = flagSet[i] & ~flagClr[i];
    assign strobes.clr[i] = flagClr[i] & ~flagSet[i];
  end
endmodule

// File: rtl/alt_dpath.sv
module alt_dpath
  import alt_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  altStrobes_t       strobes,
  input  logic [CNT_W-1:0]  immVal,
  input  logic [CNT_W-1:0]  busLow,
  output logic [CNT_W-1:0]  cntQ,
  output logic              wrapQ,
  output logic [FLAG_N-1:0] flagQ
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cntNext;
  logic             wrapNext;

  always_comb begin
    cntNext  = cntQ;
    wrapNext = 1'b0;
    if (strobes.ldImm)      cntNext = immVal;
    else if (strobes.ldBus) cntNext = busLow;
    else if (strobes.dec) begin
      cntNext  = cntQ - CNT_ONE;
      wrapNext = (cntQ == CNT_ZERO);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ  <= '0;
      wrapQ <= 1'b0;
    end else begin
      cntQ  <= cntNext;
      wrapQ <= wrapNext;
    end
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                 flagQ[i] <= 1'b0;
      else if (strobes.set[i]) flagQ[i] <= 1'b1;
      else if (strobes.clr[i]) flagQ[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/alt_unit.sv
module alt_unit
  import alt_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cntLoadImm,
  input  logic              cntLoadBus,
  input  logic              cntDec,
  input  logic [CNT_W-1:0]  immVal,
  input  logic [BUS_W-1:0]  busVal,
  input  logic [FLAG_N-1:0] flagSet,
  input  logic [FLAG_N-1:0] flagClr,
  output logic [CNT_W-1:0]  cntValue,
  output logic              wrapPulse,
  output logic              carryIn,
  output logic              endCarry,
  output logic              memWrite,
  output logic              branchSel
);
  altStrobes_t       strobes;
  logic [FLAG_N-1:0] flagQ;

  if (BUS_W > CNT_W) begin : g_busHi
    logic unusedBusHi;
    assign unusedBusHi = ^busVal[BUS_W-1:CNT_W];
  end

  alt_ctrl u_ctrl (
    .cntLoadImm (cntLoadImm),
    .cntLoadBus (cntLoadBus),
    .cntDec     (cntDec),
    .flagSet    (flagSet),
    .flagClr    (flagClr),
    .strobes    (strobes)
  );

  alt_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .immVal  (immVal),
    .busLow  (busVal[CNT_W-1:0]),
    .cntQ    (cntValue),
    .wrapQ   (wrapPulse),
    .flagQ   (flagQ)
  );

  assign carryIn   = flagQ[FLAG_CIN];
  assign endCarry  = flagQ[FLAG_ECY];
  assign memWrite  = flagQ[FLAG_MEMWR];
  assign branchSel = flagQ[FLAG_DEC];
endmodule

// File: rtl/alt_unit_chk.sv
module alt_unit_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cntLoadImm,
  input logic             cntLoadBus,
  input logic             cntDec,
  input logic [CNT_W-1:0] immVal,
  input logic [CNT_W-1:0] busLow,
  input logic [3:0]       flagSet,
  input logic [3:0]       flagClr,
  input logic [CNT_W-1:0] cntValue,
  input logic             wrapPulse,
  input logic [3:0]       flagsObs
);
  // R1
  imm_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cntLoadImm) |-> cntValue == $past(immVal));

  // R2
  bus_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cntLoadBus && !cntLoadImm) |-> cntValue == $past(busLow));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cntDec && !cntLoadImm && !cntLoadBus)
      |-> cntValue == CNT_W'($past(cntValue) - CNT_W'(1)));

  // R4
  wrap_src_chk: assert property (@(posedge clk) disable iff (rst)
    wrapPulse |-> (cntValue == '1 && $past(cntValue) == '0 && $past(cntDec)));

  // R4
  wrap_once_chk: assert property (@(posedge clk) disable iff (rst)
    wrapPulse |=> !wrapPulse);

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cntValue == '0 && !wrapPulse && flagsObs == 4'b0000));

  for (genvar i = 0; i < 4; i++) begin : g_flagChk
    // R5 R6 R7 R8
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && flagSet[i] && !flagClr[i]) |-> flagsObs[i]);
    // R5 R6 R7 R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && flagClr[i] && !flagSet[i]) |-> !flagsObs[i]);
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && flagSet[i] && flagClr[i]) |-> flagsObs[i] == $past(flagsObs[i]));
  end
endmodule

bind alt_unit alt_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cntLoadImm (cntLoadImm),
  .cntLoadBus (cntLoadBus),
  .cntDec     (cntDec),
  .immVal     (immVal),
  .busLow     (busVal[CNT_W-1:0]),
  .flagSet    (flagSet),
  .flagClr    (flagClr),
  .cntValue   (cntValue),
  .wrapPulse  (wrapPulse),
  .flagsObs   ({branchSel, memWrite, endCarry, carryIn})
);

// File: tb/test_alt_unit.sv
module test_alt_unit;
  localparam int CW = 5;
  localparam int BW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cntLoadImm = 1'b0, cntLoadBus = 1'b0, cntDec = 1'b0;
  logic [CW-1:0] immVal = '0;
  logic [BW-1:0] busVal = '0;
  logic [3:0]    flagSet = '0, flagClr = '0;
  logic [CW-1:0] cntValue;
  logic          wrapPulse, carryIn, endCarry, memWrite, branchSel;

  always #5 clk = ~clk;

  alt_unit #(.CNT_W(CW), .BUS_W(BW)) i_alt_unit (
    .clk(clk), .rst(rst), .cntLoadImm(cntLoadImm), .cntLoadBus(cntLoadBus),
    .cntDec(cntDec), .immVal(immVal), .busVal(busVal), .flagSet(flagSet),
    .flagClr(flagClr), .cntValue(cntValue), .wrapPulse(wrapPulse),
    .carryIn(carryIn), .endCarry(endCarry), .memWrite(memWrite),
    .branchSel(branchSel)
  );

  typedef struct {
    logic [CW-1:0] cnt;
    logic          wrap;
    logic [3:0]    flags;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [CW-1:0] mCnt = '0;
  logic          mWrap = 1'b0;
  logic [3:0]    mFlags = '0;

  task automatic step(input logic r, input logic li, input logic lb, input logic dc,
                      input logic [CW-1:0] im, input logic [BW-1:0] bv,
                      input logic [3:0] st, input logic [3:0] cl, input string tag);
    expItem_t e;
    @(negedge clk);
    rst = r; cntLoadImm = li; cntLoadBus = lb; cntDec = dc;
    immVal = im; busVal = bv; flagSet = st; flagClr = cl;
    if (r) begin
      mCnt = '0; mWrap = 1'b0; mFlags = '0;
    end else begin
      mWrap = dc && !li && !lb && (mCnt == '0);
      if (li)      mCnt = im;
      else if (lb) mCnt = bv[CW-1:0];
      else if (dc) mCnt = mCnt - 1'b1;
      mFlags = (mFlags | (st & ~cl)) & ~(cl & ~st);
    end
    e.cnt = mCnt; e.wrap = mWrap; e.flags = mFlags; e.tag = tag;
    expQ.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      logic [3:0] obs;
      e = expQ.pop_front();
      obs = {branchSel, memWrite, endCarry, carryIn};
      total++;
      if (cntValue !== e.cnt || wrapPulse !== e.wrap || obs !== e.flags) begin
        bad++;
        $display("FAIL %s: cnt=%0d wrap=%0b flags=%b expected cnt=%0d wrap=%0b flags=%b",
                 e.tag, cntValue, wrapPulse, obs, e.cnt, e.wrap, e.flags);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10 reset state, reset beats a decrement and flag sets
    step(1, 0, 0, 1, 5'd9, '0, 4'hF, 4'h0, "R10");
    step(1, 0, 0, 0, '0, '0, 4'h0, 4'h0, "R10");
    // R1 immediate load
    step(0, 1, 0, 0, 5'd3, '0, 4'h0, 4'h0, "R1");
    // R3 decrement to zero
    step(0, 0, 0, 1, '0, '0, 4'h0, 4'h0, "R3");
    step(0, 0, 0, 1, '0, '0, 4'h0, 4'h0, "R3");
    step(0, 0, 0, 1, '0, '0, 4'h0, 4'h0, "R3");
    // R4 underflow wrap pulses, next decrement does not
    step(0, 0, 0, 1, '0, '0, 4'h0, 4'h0, "R4");
    step(0, 0, 0, 1, '0, '0, 4'h0, 4'h0, "R4");
    // R4 loading all ones from zero gives no pulse; R3 load beats decrement
    step(0, 1, 0, 0, 5'd0, '0, 4'h0, 4'h0, "R1");
    step(0, 1, 0, 1, 5'd31, '0, 4'h0, 4'h0, "R4");
    // R2 bus load keeps low five bits only
    step(0, 0, 1, 0, 5'd2, 12'hA5C, 4'h0, 4'h0, "R2");
    // R2 immediate wins over bus
    step(0, 1, 1, 0, 5'd7, 12'h0F3, 4'h0, 4'h0, "R2");
    // R3 bus load beats decrement
    step(0, 0, 1, 1, 5'd0, 12'h009, 4'h0, 4'h0, "R3");
    step(0, 0, 0, 0, 5'd4, 12'hFFF, 4'h0, 4'h0, "R3");
    // R5..R8 flags
    step(0, 0, 0, 0, '0, '0, 4'b0001, 4'h0, "R5");
    step(0, 0, 0, 0, '0, '0, 4'h0, 4'b0001, "R5");
    step(0, 0, 0, 0, '0, '0, 4'b0010, 4'h0, "R6");
    step(0, 0, 0, 0, '0, '0, 4'b0100, 4'h0, "R7");
    step(0, 0, 0, 0, '0, '0, 4'b1000, 4'h0, "R8");
    step(0, 0, 0, 0, '0, '0, 4'h0, 4'b0010, "R6");
    // R9 simultaneous set and clear hold each flag's value
    step(0, 0, 0, 0, '0, '0, 4'hF, 4'hF, "R9");
    step(0, 0, 0, 0, '0, '0, 4'h0, 4'b1100, "R8");
    step(0, 0, 0, 0, '0, '0, 4'b0111, 4'b0101, "R9");
    step(0, 0, 0, 0, '0, '0, 4'b1001, 4'h0, "R8");
    step(0, 0, 0, 0, '0, '0, 4'hF, 4'hF, "R9");
    // R10 reset in mid operation
    step(0, 1, 0, 0, 5'd0, '0, 4'hF, 4'h0, "R1");
    step(1, 0, 0, 1, '0, '0, 4'h0, 4'h0, "R10");
    step(0, 0, 0, 1, '0, '0, 4'h0, 4'h0, "R4");
    step(0, 0, 0, 0, '0, '0, 4'h0, 4'h0, "R4");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule